// File: doc/BRIEF.md
# Prioritised Six-Channel Sample Output Port

This block gathers finished samples from several gain-control channels and sends them out over one shared 16-bit parallel bus that runs on the port clock. Every channel provides an 8-bit in-phase value, an 8-bit quadrature value and a 12-bit gain word. A one-cycle valid pulse announces each new sample. Each channel holds one sample in its own buffer until the port takes it. If a second sample arrives before the first has been taken, the new one replaces the old one and a sticky per-channel overflow flag is set.

A fixed-priority arbiter selects the next channel, and the lowest channel number always wins. The port raises a request line and waits for the downstream processor's ready (acknowledge) level before it drives the sample. The in-phase and quadrature bytes go out together in one bus cycle, marked by an IQ strobe and a 3-bit source tag. When gain output is enabled, one more cycle follows that carries the gain word and is marked by a separate gain strobe. With acknowledge held high, samples leave back to back: one cycle per sample without the gain word, two with it.

Top module: `parallel_out_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `req`, `iq_stb`, `gain_stb`, `bus`, `ch_tag` and `ovf` are all zero.
- R2: A valid pulse captured at one rising edge makes `req` go high after the following edge, provided the port was idle. At that point no strobe is high and `bus` is zero.
- R3: If `ack` is high at an edge where `req` is high and the selected sample is waiting, the next cycle is the I/Q cycle: `iq_stb`=1, `bus[15:8]`=I, `bus[7:0]`=Q, and `ch_tag` carries the source channel number.
- R4: While `ack` is low and a sample is waiting, `req` stays high, `ch_tag` holds the selected channel, both strobes stay low and `bus` stays zero. The I/Q cycle comes one edge after `ack` is seen high.
- R5: If `gain_en` is high when a sample is selected, the cycle after its I/Q cycle has `gain_stb`=1 and `iq_stb`=0, with `bus[11:0]` = the gain word and `bus[15:12]` = 0. The two strobes are never high together.
- R6: When several channels are pending, they are served in ascending channel order, 0 through 5.
- R7: With `ack` held high, the next pending sample starts in the cycle right after the last word of the current sample. Throughput is one cycle per sample without the gain word and two with it.
- R8: Each channel buffers one sample. A valid pulse on a channel whose previous sample is still pending and is not being taken at that same edge replaces the old sample and sets that channel's bit in `ovf`. The bit stays set until reset. A pulse at the same edge as the take causes no overflow.
- R9: After the last word of a sample, `req` falls if no channel is pending. Whenever neither strobe is high, `bus` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gain_en | input | 1 | Append a gain-word cycle to each sample selected while high |
| ch_valid | input | NUM_CH | One-cycle new-sample pulse per channel |
| ch_i | input | NUM_CH*8 | In-phase byte per channel, channel c in bits [8c+7:8c] |
| ch_q | input | NUM_CH*8 | Quadrature byte per channel, same layout |
| ch_gain | input | NUM_CH*12 | Gain word per channel, channel c in bits [12c+11:12c] |
| ack | input | 1 | Downstream ready level |
| req | output | 1 | A sample is being offered or sent |
| bus | output | 16 | Shared data bus |
| iq_stb | output | 1 | Bus holds I/Q data |
| gain_stb | output | 1 | Bus holds a gain word |
| ch_tag | output | 3 | Source channel number |
| ovf | output | NUM_CH | Sticky per-channel overwrite flags |

## Verification
The bench builds the port with its default of six channels. All six sources can therefore contend at once, and the lowest-priority channel, tag 5, is reached only after five others. A gain-enabled burst on alternate channels gives alternating strobe cycles. Bursts run under a pseudo-random acknowledge pattern, which stalls the port in the waiting state and in the middle of a burst. Directed sequences on a single channel cause an overwrite and also a take and a new arrival on the same edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int HALF_W = 8;
    localparam int GAIN_W = 12;
    localparam int BUS_W  = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] i_val;
        logic [HALF_W-1:0] q_val;
        logic [GAIN_W-1:0] gain;
    } sample_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WAIT,
        PS_IQ,
        PS_GAIN
    } port_state_e;

    function automatic logic [BUS_W-1:0] iq_word(sample_t s);
        return {s.i_val, s.q_val};
    endfunction

    function automatic logic [BUS_W-1:0] gain_word(sample_t s);
        return {{(BUS_W - GAIN_W){1'b0}}, s.gain};
    endfunction
endpackage

// File: rtl/pport_chan_buf.sv
module pport_chan_buf
    import pport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_vld,
    input  sample_t in_samp,
    input  logic    take,
    output logic    pending,
    output sample_t held,
    output logic    ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            ovf     <= 1'b0;
            held    <= '0;
        end else begin
            if (in_vld)
                held <= in_samp;
            pending <= in_vld | (pending & ~take);
            if (in_vld && pending && !take)
                ovf <= 1'b1;
        end
    end

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    assert_take_pending_R8: assert property (@(posedge clk) disable iff (rst)
        take |-> pending);
endmodule

// File: rtl/pport_arb.sv
module pport_arb #(
    parameter int N     = 6,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [TAG_W-1:0] sel
);
    always_comb begin
        any = |pend;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k])
                sel = TAG_W'(k);
        end
    end

    assert_prio_R6: assert property (@(posedge clk) disable iff (rst)
        any |-> ((pend & ((N'(1) << sel) - N'(1))) == '0) && pend[sel]);
endmodule

// File: rtl/pport_seq.sv
module pport_seq
    import pport_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any,
    input  logic [TAG_W-1:0] sel_tag,
    input  sample_t          sel_samp,
    input  logic             gain_en,
    input  logic             ack,
    output logic             load,
    output logic             req,
    output logic [BUS_W-1:0] bus,
    output logic             iq_stb,
    output logic             gain_stb,
    output logic [TAG_W-1:0] ch_tag
);
    port_state_e      st, st_n;
    sample_t          slot;
    logic [TAG_W-1:0] slot_tag;
    logic             slot_gen;
    logic             finish;

    always_comb begin
        st_n   = st;
        load   = 1'b0;
        finish = 1'b0;
        case (st)
            PS_IDLE: if (any) begin
                load = 1'b1;
                st_n = PS_WAIT;
            end
            PS_WAIT: if (ack) st_n = PS_IQ;
            PS_IQ:   if (slot_gen) st_n = PS_GAIN; else finish = 1'b1;
            PS_GAIN: finish = 1'b1;
            default: st_n = PS_IDLE;
        endcase
        if (finish) begin
            if (any) begin
                load = 1'b1;
                st_n = ack ? PS_IQ : PS_WAIT;
            end else begin
                st_n = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_IDLE;
            slot     <= '0;
            slot_tag <= '0;
            slot_gen <= 1'b0;
        end else begin
            st <= st_n;
            if (load) begin
                slot     <= sel_samp;
                slot_tag <= sel_tag;
                slot_gen <= gain_en;
            end
        end
    end

    always_comb begin
        req      = (st != PS_IDLE);
        iq_stb   = (st == PS_IQ);
        gain_stb = (st == PS_GAIN);
        ch_tag   = req ? slot_tag : '0;
        case (st)
            PS_IQ:   bus = iq_word(slot);
            PS_GAIN: bus = gain_word(slot);
            default: bus = '0;
        endcase
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(iq_stb && gain_stb));

    assert_gain_follows_iq_R5: assert property (@(posedge clk) disable iff (rst)
        gain_stb |-> $past(iq_stb));

    assert_gain_pad_R5: assert property (@(posedge clk) disable iff (rst)
        gain_stb |-> (bus[BUS_W-1:GAIN_W] == '0));

    assert_iq_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        iq_stb |-> $past(ack));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st == PS_WAIT && !ack) |=> (req && $stable(ch_tag) && !iq_stb && !gain_stb));

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (!iq_stb && !gain_stb) |-> (bus == '0));
endmodule

// File: rtl/parallel_out_port.sv
module parallel_out_port
    import pport_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int TAG_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     gain_en,
    input  logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH*HALF_W-1:0] ch_i,
    input  logic [NUM_CH*HALF_W-1:0] ch_q,
    input  logic [NUM_CH*GAIN_W-1:0] ch_gain,
    input  logic                     ack,
    output logic                     req,
    output logic [BUS_W-1:0]         bus,
    output logic                     iq_stb,
    output logic                     gain_stb,
    output logic [TAG_W-1:0]         ch_tag,
    output logic [NUM_CH-1:0]        ovf
);
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] take;
    sample_t           held [NUM_CH];
    logic              any;
    logic [TAG_W-1:0]  sel;
    logic              load;
    sample_t           sel_samp;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sample_t in_s;
        assign in_s.i_val = ch_i[c*HALF_W +: HALF_W];
        assign in_s.q_val = ch_q[c*HALF_W +: HALF_W];
        assign in_s.gain  = ch_gain[c*GAIN_W +: GAIN_W];
        assign take[c]    = load && (sel == TAG_W'(c));

        pport_chan_buf u_buf (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (ch_valid[c]),
            .in_samp (in_s),
            .take    (take[c]),
            .pending (pend[c]),
            .held    (held[c]),
            .ovf     (ovf[c])
        );
    end

    pport_arb #(.N(NUM_CH), .TAG_W(TAG_W)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .any  (any),
        .sel  (sel)
    );

    assign sel_samp = held[sel];

    pport_seq #(.TAG_W(TAG_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .any      (any),
        .sel_tag  (sel),
        .sel_samp (sel_samp),
        .gain_en  (gain_en),
        .ack      (ack),
        .load     (load),
        .req      (req),
        .bus      (bus),
        .iq_stb   (iq_stb),
        .gain_stb (gain_stb),
        .ch_tag   (ch_tag)
    );

    assert_tag_range_R3: assert property (@(posedge clk) disable iff (rst)
        req |-> (ch_tag < TAG_W'(NUM_CH)));
endmodule

// File: tb/tb_parallel_out_port.sv
module tb_parallel_out_port;
    localparam int NCH = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            gain_en = 1'b0;
    logic [NCH-1:0]  vld = '0;
    logic [NCH*8-1:0]  ii = '0;
    logic [NCH*8-1:0]  qq = '0;
    logic [NCH*12-1:0] gg = '0;
    logic            ack = 1'b0;
    logic            req, iq_stb, gain_stb;
    logic [15:0]     bus;
    logic [2:0]      ch_tag;
    logic [NCH-1:0]  ovf;

    parallel_out_port #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .gain_en(gain_en), .ch_valid(vld),
        .ch_i(ii), .ch_q(qq), .ch_gain(gg), .ack(ack),
        .req(req), .bus(bus), .iq_stb(iq_stb), .gain_stb(gain_stb),
        .ch_tag(ch_tag), .ovf(ovf)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          ch;
        logic [15:0] iq;
        logic [11:0] g;
        bit          has_g;
    } exp_t;

    exp_t        sb[$];
    int          errors = 0;
    int          checks = 0;
    bit          want_gain = 0;
    logic [11:0] gexp;
    bit          stress = 0;
    logic [7:0]  lfsr = 8'hA5;

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // monitor: pops expected samples as they appear on the bus
    always @(negedge clk) begin
        if (!rst) begin
            if (want_gain) begin
                chk(gain_stb && !iq_stb, "R5", "gain strobe", {gain_stb, iq_stb}, 2'b10);
                chk(bus == {4'b0, gexp}, "R5", "gain word", bus, {4'b0, gexp});
                want_gain = 0;
            end else if (gain_stb) begin
                chk(0, "R5", "unexpected gain strobe", 1, 0);
            end else if (iq_stb) begin
                if (sb.size() == 0) begin
                    chk(0, "R3", "unexpected iq strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(ch_tag == 3'(e.ch), "R6", "source tag order", ch_tag, e.ch);
                    chk(bus == e.iq, "R3", "iq word", bus, e.iq);
                    if (e.has_g) begin
                        want_gain = 1;
                        gexp = e.g;
                    end
                end
            end else begin
                chk(bus == 16'h0, "R9", "bus between words", bus, 0);
            end
        end
    end

    // pseudo-random ready level in stress mode
    always @(negedge clk) begin
        if (stress) begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ack  <= lfsr[0] | lfsr[2];
        end
    end

    // driver: called at a negedge; pulses valid across one rising edge
    task automatic send(logic [NCH-1:0] mask, int seed, bit push);
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                exp_t e;
                vld[c] = 1'b1;
                ii[c*8 +: 8]   = 8'(seed * 7 + c * 16 + 1);
                qq[c*8 +: 8]   = 8'(seed * 13 + c * 3 + 5);
                gg[c*12 +: 12] = 12'(seed * 101 + c * 257 + 9);
                e.ch = c;
                e.iq = {ii[c*8 +: 8], qq[c*8 +: 8]};
                e.g = gg[c*12 +: 12];
                e.has_g = gain_en;
                if (push) sb.push_back(e);
            end
        end
        @(negedge clk);
        vld = '0;
    endtask

    task automatic drain();
        for (int n = 0; n < 400; n++) begin
            if (!req && sb.size() == 0 && !want_gain) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req == 0 && iq_stb == 0 && gain_stb == 0, "R1", "control in reset",
            {req, iq_stb, gain_stb}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus == 0 && ch_tag == 0 && ovf == 0 && req == 0, "R1", "outputs after reset",
            {bus, ch_tag, ovf}, 0);

        // single sample, ready already high
        ack = 1'b1;
        send(6'b000010, 1, 1);
        chk(req == 0, "R2", "req before selection", req, 0);
        @(negedge clk);
        chk(req && !iq_stb && bus == 0, "R2", "req raised, waiting", {req, iq_stb}, 2'b10);
        @(negedge clk);
        chk(iq_stb, "R3", "iq cycle one edge after req", iq_stb, 1);
        @(negedge clk);
        chk(!req, "R9", "req drops when nothing pending", req, 0);
        drain();

        // stall with ready low
        ack = 1'b0;
        send(6'b001000, 2, 1);
        @(negedge clk);
        for (int n = 0; n < 4; n++) begin
            chk(req && !iq_stb && !gain_stb && bus == 0 && ch_tag == 3, "R4", "hold while not ready",
                {req, iq_stb, gain_stb, ch_tag}, {1'b1, 1'b0, 1'b0, 3'd3});
            @(negedge clk);
        end
        ack = 1'b1;
        @(negedge clk);
        chk(iq_stb, "R4", "iq one edge after ready", iq_stb, 1);
        drain();

        // all six contend, no gain: back-to-back
        gain_en = 1'b0;
        send(6'b111111, 3, 1);
        @(negedge clk);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            chk(iq_stb, "R7", "contiguous iq cycles", iq_stb, 1);
        end
        @(negedge clk);
        chk(!req, "R9", "req low after burst", req, 0);
        drain();

        // gain enabled on alternate channels: two cycles per sample
        gain_en = 1'b1;
        send(6'b101010, 4, 1);
        @(negedge clk);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            chk((n % 2 == 0) ? iq_stb : gain_stb, "R7", "iq/gain alternation",
                {iq_stb, gain_stb}, (n % 2 == 0) ? 2 : 1);
        end
        drain();
        gain_en = 1'b0;

        // overwrite of a pending sample
        ack = 1'b0;
        send(6'b000100, 5, 1);
        @(negedge clk);
        send(6'b000100, 6, 0);
        send(6'b000100, 7, 1);
        chk(ovf == 6'b000100, "R8", "overflow flag set", ovf, 6'b000100);
        ack = 1'b1;
        drain();

        // arrival on the same edge as the take: no overflow
        send(6'b010000, 8, 1);
        send(6'b010000, 9, 1);
        drain();
        chk(ovf == 6'b000100, "R8", "no overflow on take edge, sticky kept", ovf, 6'b000100);

        // random ready pattern
        stress = 1;
        for (int b = 0; b < 12; b++) begin
            logic [NCH-1:0] m;
            m = 6'((b * 37 + 11) ^ (b << 2));
            if (m == 0) m = 6'b100001;
            gain_en = b[0];
            send(m, 20 + b, 1);
            drain();
        end
        stress = 0;
        ack = 1'b1;
        drain();
        chk(sb.size() == 0, "R6", "scoreboard empty", sb.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule